// File: doc/BRIEF.md
# Dual-Channel Converter Command Receiver

This block is the digital front end of a two-channel 8-bit converter. A host sends 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line. The block samples all three lines with its own system clock. It rebuilds each word and decodes a two-bit target code that is split across the word. It then writes channel A, channel B or a holding buffer. Every word also carries a fast/slow speed flag and a power-down flag, and both flags are updated on every commit.

The holding buffer lets the two channels change together. The host first loads the holding buffer, then sends a channel A word, which moves the holding buffer into channel B in the same clock cycle. On each commit the block raises a one-cycle update strobe with a two-bit code that reports which channel registers were written, so downstream logic and a model can follow every change.

The system clock must run at least four times the serial clock rate, because serial edges are found by comparing synchronised samples.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: After reset both channel codes, the holding buffer, the speed flag, the power flag, the strobe and the change code are all zero. A channel A word sent after reset moves zero into channel B.
- R2: A falling edge of the select line starts a frame. Bits are taken most significant first, one on each falling serial-clock edge while select is low. The 16th bit commits the frame.
- R3: Word layout: bit 15 is the high target bit, bit 14 is the speed bit, bit 13 is the power bit, bit 12 is the low target bit, bits 11..4 are the data code (bit 11 most significant) and bits 3..0 are padding that is ignored.
- R4: Target 00 writes the data code to channel B and to the holding buffer. Channel A is unchanged.
- R5: Target 01 writes the holding buffer only. Both channel outputs are unchanged.
- R6: Target 10 writes the data code to channel A and copies the old holding buffer into channel B, both in the same cycle.
- R7: Target 11 changes neither channel nor the holding buffer, but still updates the speed and power flags.
- R8: On every commit, fast_o takes the speed bit (1 = fast, 0 = slow) and pdown_o takes the power bit (1 = powered down, 0 = normal), whatever the target code.
- R9: If select rises after 1 to 15 bits, the frame commits, and the bits that were not received count as zero. A frame with no bits commits nothing.
- R10: Serial clocks after the 16th bit are ignored until select rises and falls again. They cause no second commit.
- R11: A word sent as two 8-bit bursts, with select held low and the serial clock paused between them, gives the same result as one 16-bit burst.
- R12: upd_o is high for exactly one cycle per commit, in the same cycle the new codes and flags appear. upd_what_o bit 0 means channel A was written and bit 1 means channel B was written. upd_what_o is zero when upd_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdin_i | input | 1 | Serial data, asynchronous |
| code_a_o | output | 8 | Channel A code |
| code_b_o | output | 8 | Channel B code |
| fast_o | output | 1 | Speed flag, 1 = fast |
| pdown_o | output | 1 | Power-down flag, 1 = powered down |
| upd_o | output | 1 | One-cycle commit strobe |
| upd_what_o | output | 2 | Written channels: bit 0 = A, bit 1 = B |

## Verification
The channel A write and the transfer of the holding buffer into channel B fall in the same cycle, and the speed and power flags also change in that cycle. This is provoked by loading the holding buffer with one value and then sending a channel A word that carries a different value and new flag bits. The result is judged by checking for one strobe with change code 11, with both channel codes and both flags new at that same sample. A separate case loads the holding buffer from a truncated frame and then transfers it, which shows that a partial commit and a later transfer work together.

// File: rtl/dual_dac_cmd_pkg.sv
package dual_dac_cmd_pkg;

    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 8;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int SEL_HI   = 15;
    localparam int SPD_BIT  = 14;
    localparam int PWR_BIT  = 13;
    localparam int SEL_LO   = 12;
    localparam int CODE_MSB = 11;
    localparam int CODE_LSB = CODE_MSB - CODE_W + 1;
    localparam int WHAT_W   = 2;

    typedef enum logic [1:0] {
        TGT_B_HOLD = 2'b00,
        TGT_HOLD   = 2'b01,
        TGT_A_XFER = 2'b10,
        TGT_RSVD   = 2'b11
    } target_e;

    typedef struct packed {
        logic               cs_prev;
        logic               sclk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] word;
        logic               done;
        logic               commit;
    } rx_state_t;

    typedef struct packed {
        logic [CODE_W-1:0]  chan_a;
        logic [CODE_W-1:0]  chan_b;
        logic [CODE_W-1:0]  hold;
        logic               fast;
        logic               pdown;
        logic               upd;
        logic [WHAT_W-1:0]  what;
    } lat_state_t;

endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/dual_dac_frame_rx.sv
module dual_dac_frame_rx
    import dual_dac_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               sdin_s,
    output logic               commit_o,
    output logic [FRAME_W-1:0] word_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

    rx_state_t rx_d, rx_q;
    logic      cs_fall, cs_rise, sclk_fall;

    always_comb begin
        rx_d           = rx_q;
        rx_d.commit    = 1'b0;
        rx_d.cs_prev   = cs_n_s;
        rx_d.sclk_prev = sclk_s;
        cs_fall        = rx_q.cs_prev & ~cs_n_s;
        cs_rise        = ~rx_q.cs_prev & cs_n_s;
        sclk_fall      = rx_q.sclk_prev & ~sclk_s;

        if (cs_fall) begin
            rx_d.cnt  = '0;
            rx_d.word = '0;
            rx_d.done = 1'b0;
        end else if (cs_rise) begin
            if (!rx_q.done && rx_q.cnt != '0) begin
                rx_d.commit = 1'b1;
            end
            rx_d.done = 1'b1;
        end else if (!cs_n_s && sclk_fall && !rx_q.done) begin
            for (int i = 0; i < FRAME_W; i++) begin
                if (i == FRAME_W - 1 - int'(rx_q.cnt)) begin
                    rx_d.word[i] = sdin_s;
                end
            end
            rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt == LAST_CNT) begin
                rx_d.commit = 1'b1;
                rx_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q           <= '0;
            rx_q.cs_prev   <= 1'b1;
            rx_q.done      <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign commit_o = rx_q.commit;
    assign word_o   = rx_q.word;
endmodule

// File: rtl/dual_dac_latch_bank.sv
module dual_dac_latch_bank
    import dual_dac_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [FRAME_W-1:0] word_i,
    output logic [CODE_W-1:0]  chan_a_o,
    output logic [CODE_W-1:0]  chan_b_o,
    output logic               fast_o,
    output logic               pdown_o,
    output logic               upd_o,
    output logic [WHAT_W-1:0]  what_o
);
    lat_state_t        lat_d, lat_q;
    target_e           tgt;
    logic [CODE_W-1:0] data;

    always_comb begin
        lat_d      = lat_q;
        lat_d.upd  = 1'b0;
        lat_d.what = '0;
        tgt        = target_e'({word_i[SEL_HI], word_i[SEL_LO]});
        data       = word_i[CODE_MSB:CODE_LSB];

        if (commit_i) begin
            lat_d.upd   = 1'b1;
            lat_d.fast  = word_i[SPD_BIT];
            lat_d.pdown = word_i[PWR_BIT];
            unique case (tgt)
                TGT_B_HOLD: begin
                    lat_d.chan_b = data;
                    lat_d.hold   = data;
                    lat_d.what   = 2'b10;
                end
                TGT_HOLD: begin
                    lat_d.hold = data;
                end
                TGT_A_XFER: begin
                    lat_d.chan_a = data;
                    lat_d.chan_b = lat_q.hold;
                    lat_d.what   = 2'b11;
                end
                TGT_RSVD: begin
                    lat_d.what = 2'b00;
                end
                default: begin
                    lat_d.what = 2'b00;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign chan_a_o = lat_q.chan_a;
    assign chan_b_o = lat_q.chan_b;
    assign fast_o   = lat_q.fast;
    assign pdown_o  = lat_q.pdown;
    assign upd_o    = lat_q.upd;
    assign what_o   = lat_q.what;
endmodule

// File: rtl/dual_dac_cmd_if.sv
module dual_dac_cmd_if
    import dual_dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              fast_o,
    output logic              pdown_o,
    output logic              upd_o,
    output logic [WHAT_W-1:0] upd_what_o
);
    localparam int           SYNC_W   = 3;
    localparam logic [2:0]   SYNC_RST = 3'b100;

    logic [SYNC_W-1:0]  pins_s;
    logic               rx_commit;
    logic [FRAME_W-1:0] rx_word;

    dual_dac_sync #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, sclk_i, sdin_i}),
        .sync_o  (pins_s)
    );

    dual_dac_frame_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdin_s   (pins_s[0]),
        .commit_o (rx_commit),
        .word_o   (rx_word)
    );

    dual_dac_latch_bank u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (rx_commit),
        .word_i   (rx_word),
        .chan_a_o (code_a_o),
        .chan_b_o (code_b_o),
        .fast_o   (fast_o),
        .pdown_o  (pdown_o),
        .upd_o    (upd_o),
        .what_o   (upd_what_o)
    );
endmodule

// File: rtl/dual_dac_cmd_chk.sv
module dual_dac_cmd_chk
    import dual_dac_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_a_o,
    input logic [CODE_W-1:0] code_b_o,
    input logic              fast_o,
    input logic              pdown_o,
    input logic              upd_o,
    input logic [WHAT_W-1:0] upd_what_o,
    input logic              frame_commit,
    input logic [FRAME_W-1:0] frame_word
);
    // R12
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R12
    what_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> (upd_what_o == 2'b00));

    // R5
    chan_a_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a_o != $past(code_a_o)) |-> (upd_o && upd_what_o[0]));

    // R5
    chan_b_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_b_o != $past(code_b_o)) |-> (upd_o && upd_what_o[1]));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> ($stable(fast_o) && $stable(pdown_o)));

    // R8
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_commit |=> (fast_o == $past(frame_word[SPD_BIT]) &&
                          pdown_o == $past(frame_word[PWR_BIT])));

    // R4
    b_hold_what_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_commit && !frame_word[SEL_HI] && !frame_word[SEL_LO])
            |=> (upd_o && upd_what_o == 2'b10));

    // R6
    a_xfer_what_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_commit && frame_word[SEL_HI] && !frame_word[SEL_LO])
            |=> (upd_o && upd_what_o == 2'b11));

    // R7
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_commit && frame_word[SEL_HI] && frame_word[SEL_LO])
            |=> (upd_o && upd_what_o == 2'b00 && $stable(code_a_o) && $stable(code_b_o)));
endmodule

bind dual_dac_cmd_if dual_dac_cmd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_a_o     (code_a_o),
    .code_b_o     (code_b_o),
    .fast_o       (fast_o),
    .pdown_o      (pdown_o),
    .upd_o        (upd_o),
    .upd_what_o   (upd_what_o),
    .frame_commit (rx_commit),
    .frame_word   (rx_word)
);

// File: tb/dual_dac_cmd_if_bench.sv
`timescale 1ns/1ps
module dual_dac_cmd_if_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic [7:0] code_a, code_b;
    logic       fast, pdown, upd;
    logic [1:0] what;

    int checks = 0;
    int fails  = 0;
    int upd_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    logic [1:0] last_what = 2'b00;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_dac_cmd_if u_dual_dac_cmd_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .sdin_i     (sdin),
        .code_a_o   (code_a),
        .code_b_o   (code_b),
        .fast_o     (fast),
        .pdown_o    (pdown),
        .upd_o      (upd),
        .upd_what_o (what)
    );

    always @(negedge clk) begin
        if (upd) begin
            upd_cnt   <= upd_cnt + 1;
            last_what <= what;
            run_len   <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    typedef struct packed {
        logic [15:0] word;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [1:0]  what;
        logic        fast;
        logic        pd;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h45A0, 8'h00, 8'h5A, 2'b10, 1'b1, 1'b0},  // r4_ B and hold
        '{16'h13C0, 8'h00, 8'h5A, 2'b00, 1'b0, 1'b0},  // r5_ hold only
        '{16'hCC30, 8'hC3, 8'h3C, 2'b11, 1'b1, 1'b0},  // r6_ A plus transfer
        '{16'hBFF0, 8'hC3, 8'h3C, 2'b00, 1'b0, 1'b1},  // r7_ reserved, flags move
        '{16'h0000, 8'hC3, 8'h00, 2'b10, 1'b0, 1'b0},  // r4_ zero code
        '{16'hEFF0, 8'hFF, 8'h00, 2'b11, 1'b1, 1'b1},  // r6_ full scale, both flags
        '{16'h1810, 8'hFF, 8'h00, 2'b00, 1'b0, 1'b0},  // r5_
        '{16'h8010, 8'h01, 8'h81, 2'b11, 1'b0, 1'b0}   // r6_
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            sdin = w[15 - i];
            sclk = 1'b1;
            wait_clk(5);
            sclk = 1'b0;
            wait_clk(5);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        cs_n = 1'b0;
        wait_clk(5);
        shift_bits(w, 0, 16);
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
    endtask

    initial begin
        int base;
        do_reset();
        // R1 reset state
        check("R1 code_a", code_a, 8'h00);
        check("R1 code_b", code_b, 8'h00);
        check("R1 flags", {fast, pdown}, 2'b00);
        check("R1 strobe", {upd, what}, 3'b000);

        // R2 R3 table of full frames
        for (int v = 0; v < NVEC; v++) begin
            base = upd_cnt;
            send_word(VECS[v].word);
            check($sformatf("R2 vec%0d commits", v), upd_cnt - base, 1);
            check($sformatf("R3 vec%0d code_a", v), code_a, VECS[v].a);
            check($sformatf("R3 vec%0d code_b", v), code_b, VECS[v].b);
            check($sformatf("R12 vec%0d what", v), last_what, VECS[v].what);
            check($sformatf("R8 vec%0d flags", v), {fast, pdown}, {VECS[v].fast, VECS[v].pd});
        end

        // R9 truncated frame: 8 bits of 0x13C0 -> 0x1300, hold = 0x30
        base = upd_cnt;
        cs_n = 1'b0; wait_clk(5);
        shift_bits(16'h13C0, 0, 8);
        wait_clk(3); cs_n = 1'b1; wait_clk(12);
        check("R9 partial commits", upd_cnt - base, 1);
        check("R9 partial what", last_what, 2'b00);
        check("R9 outputs kept", {code_a, code_b}, 16'h0181);
        send_word(16'h8AA0);
        check("R9 hold from partial", {code_a, code_b}, 16'hAA30);

        // R9 empty frame
        base = upd_cnt;
        cs_n = 1'b0; wait_clk(10); cs_n = 1'b1; wait_clk(12);
        check("R9 empty frame", upd_cnt - base, 0);

        // R10 extra clocks after 16th bit
        base = upd_cnt;
        cs_n = 1'b0; wait_clk(5);
        shift_bits(16'h0770, 0, 16);
        shift_bits(16'hFFFF, 0, 4);
        wait_clk(3); cs_n = 1'b1; wait_clk(12);
        check("R10 one commit", upd_cnt - base, 1);
        check("R10 code_b", code_b, 8'h77);
        check("R10 code_a", code_a, 8'hAA);

        // R11 two byte bursts
        base = upd_cnt;
        cs_n = 1'b0; wait_clk(5);
        shift_bits(16'hC550, 0, 8);
        wait_clk(40);
        shift_bits(16'hC550, 8, 8);
        wait_clk(3); cs_n = 1'b1; wait_clk(12);
        check("R11 one commit", upd_cnt - base, 1);
        check("R11 channels", {code_a, code_b}, 16'h5577);
        check("R11 flags", {fast, pdown}, 2'b10);

        // R12 strobe width
        check("R12 strobe width", max_run, 1);

        // R1 hold cleared by reset
        do_reset();
        check("R1 after reset", {code_a, code_b, fast, pdown}, 18'h0);
        send_word(16'h8110);
        check("R1 hold zero", {code_a, code_b}, 16'h1100);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule